// File: doc/BRIEF.md
# Chained Converter Readback Controller

This block is the host end of a serial link to a chain of sampling converters. Every device in the chain shares one conversion-start line and one serial clock. The block captures a single serial data input, which comes from the device wired closest to the host. After a start request it raises the convert line while the serial clock is held low. This puts the chain into the mode where no busy indicator is used. The block then waits a fixed number of system clocks for the conversion to finish.

Next it drives 18 clock pulses per chained device. It samples the data line on each falling clock edge and rebuilds one 18-bit word per device, MSB first. The device nearest the host comes first. Each finished word appears on a parallel output with a one-cycle strobe and its position in the chain. After the last pulse the convert line drops and the block returns to idle.

Top module: `chain_adc_reader`

## Requirements
- R1: While reset is held and on the first cycle after it, `cnv_o`, `sclk_o` and `word_valid_o` are low.
- R2: A `start_i` seen high in idle raises `cnv_o` on the next clock edge, and `sclk_o` is low at that moment.
- R3: The first `sclk_o` rising edge comes exactly `CONV_CYC + HALF_DIV` system clocks after `cnv_o` rises. After that, every high phase and every low phase of `sclk_o` lasts exactly `HALF_DIV` system clocks.
- R4: `cnv_o` stays high from its rise through the final falling edge of `sclk_o`, and `sclk_o` is never high while `cnv_o` is low.
- R5: One readback issues exactly `18 × N_DEV` pulses on `sclk_o`.
- R6: Each bit is the `sdi_i` value present on the system clock where `sclk_o` falls. Each 18-bit word is built with its first received bit in bit 17 (MSB first).
- R7: Exactly `N_DEV` words are delivered per readback. Each has a one-cycle `word_valid_o` pulse. `word_idx_o` counts 0, 1, … in arrival order, and index 0 is the device nearest the host.
- R8: On the clock edge of the last `sclk_o` fall, `cnv_o` goes low. Both lines then stay low until the next start.
- R9: `start_i` has no effect while a conversion or readback is in progress. The pulse count, the word count and the convert-line timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to convert and read the chain |
| cnv_o | output | 1 | Conversion-start line to all devices |
| sclk_o | output | 1 | Serial clock to all devices |
| sdi_i | input | 1 | Serial data from the nearest device |
| word_o | output | 18 | Assembled sample, MSB in bit 17 |
| word_valid_o | output | 1 | One-cycle strobe for `word_o` |
| word_idx_o | output | clog2(N_DEV), min 1 | Chain position of `word_o`, 0 = nearest |

## Verification
The assertions assume that `sdi_i` is synchronous to `clk` and changes only after a falling `sclk_o` edge, as a chained shift register does. They also assume `start_i` is a clean synchronous level. The bench drives `sdi_i` from a behavioural shift register that updates just after each `sclk_o` fall. It changes `start_i` only at falling system-clock edges, including requests held through the conversion wait and injected during readback.

// File: rtl/chain_rd_pkg.sv
package chain_rd_pkg;

    localparam int unsigned WORD_W = 18;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_READ = 2'd2
    } rd_state_e;

    function automatic int unsigned clog2_min1(input int unsigned v);
        return (v <= 1) ? 1 : $clog2(v);
    endfunction

endpackage

// File: rtl/cr_conv_timer.sv
module cr_conv_timer
    import chain_rd_pkg::*;
#(
    parameter int unsigned CONV_CYC = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int unsigned CW = clog2_min1(CONV_CYC);

    logic [CW-1:0] cnt_q;

    assign done = run && (cnt_q == CW'(CONV_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (!done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3: the wait never ends on the first cycle of a run unless the wait is one cycle
    p_wait_not_early_r3: assert property (@(posedge clk) disable iff (rst)
        (run && !$past(run) && (CONV_CYC > 1)) |-> !done);

endmodule

// File: rtl/cr_sclk_gen.sv
module cr_sclk_gen
    import chain_rd_pkg::*;
#(
    parameter int unsigned HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sclk,
    output logic fall_tick
);
    localparam int unsigned DW = clog2_min1(HALF_DIV);

    logic [DW-1:0] div_q;
    logic          wrap;

    assign wrap      = run && (div_q == DW'(HALF_DIV - 1));
    assign fall_tick = wrap && sclk;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_q <= '0;
            sclk  <= 1'b0;
        end else if (wrap) begin
            div_q <= '0;
            sclk  <= ~sclk;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // R3: the clock leaves its idle level only while the read phase is active
    p_sclk_rise_in_run_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> $past(run));

endmodule

// File: rtl/cr_deser.sv
module cr_deser
    import chain_rd_pkg::*;
#(
    parameter int unsigned N_DEV = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clear,
    input  logic                         fall_tick,
    input  logic                         sdi,
    output logic [WORD_W-1:0]            word_o,
    output logic                         valid_o,
    output logic [clog2_min1(N_DEV)-1:0] idx_o,
    output logic                         last_o
);
    localparam int unsigned BW = clog2_min1(WORD_W);
    localparam int unsigned IW = clog2_min1(N_DEV);

    logic [WORD_W-2:0] sh_q;
    logic [BW-1:0]     bit_q;
    logic [IW-1:0]     word_q;
    logic              word_end;

    assign word_end = fall_tick && (bit_q == BW'(WORD_W - 1));
    assign last_o   = word_end && (word_q == IW'(N_DEV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            bit_q   <= '0;
            word_q  <= '0;
            word_o  <= '0;
            valid_o <= 1'b0;
            idx_o   <= '0;
        end else begin
            valid_o <= 1'b0;
            if (clear) begin
                bit_q  <= '0;
                word_q <= '0;
            end else if (fall_tick) begin
                sh_q <= {sh_q[WORD_W-3:0], sdi};
                if (word_end) begin
                    bit_q   <= '0;
                    word_q  <= last_o ? '0 : word_q + 1'b1;
                    word_o  <= {sh_q, sdi};
                    valid_o <= 1'b1;
                    idx_o   <= word_q;
                end else begin
                    bit_q <= bit_q + 1'b1;
                end
            end
        end
    end

    // R6: a word is only published on the cycle after a clock fall
    p_word_after_fall_r6: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $past(fall_tick));

    // R7: each strobe lasts a single cycle
    p_valid_single_r7: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

endmodule

// File: rtl/chain_adc_reader.sv
module chain_adc_reader
    import chain_rd_pkg::*;
#(
    parameter int unsigned N_DEV    = 3,
    parameter int unsigned HALF_DIV = 2,
    parameter int unsigned CONV_CYC = 12
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start_i,
    output logic                         cnv_o,
    output logic                         sclk_o,
    input  logic                         sdi_i,
    output logic [WORD_W-1:0]            word_o,
    output logic                         word_valid_o,
    output logic [clog2_min1(N_DEV)-1:0] word_idx_o
);
    rd_state_e state_q;
    logic      conv_done;
    logic      fall_tick;
    logic      last_bit;
    logic      accept;

    assign accept = (state_q == ST_IDLE) && start_i;

    cr_conv_timer #(.CONV_CYC(CONV_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (state_q == ST_CONV),
        .done (conv_done)
    );

    cr_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
        .clk       (clk),
        .rst       (rst),
        .run       (state_q == ST_READ),
        .sclk      (sclk_o),
        .fall_tick (fall_tick)
    );

    cr_deser #(.N_DEV(N_DEV)) u_deser (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .fall_tick (fall_tick),
        .sdi       (sdi_i),
        .word_o    (word_o),
        .valid_o   (word_valid_o),
        .idx_o     (word_idx_o),
        .last_o    (last_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnv_o   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    state_q <= ST_CONV;
                    cnv_o   <= 1'b1;
                end
                ST_CONV: if (conv_done) begin
                    state_q <= ST_READ;
                end
                ST_READ: if (last_bit) begin
                    state_q <= ST_IDLE;
                    cnv_o   <= 1'b0;
                end
                default: begin
                    state_q <= ST_IDLE;
                    cnv_o   <= 1'b0;
                end
            endcase
        end
    end

    // R2: the chain must see the serial clock low when convert rises
    p_sclk_low_at_cnv_rise_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(cnv_o) |-> !sclk_o);

    // R4: the serial clock only pulses under a high convert line
    p_cnv_covers_sclk_r4: assert property (@(posedge clk) disable iff (rst)
        sclk_o |-> cnv_o);

    // R8: convert drops with the clock already back at its idle level
    p_end_idle_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(cnv_o) |-> (!sclk_o && $past(sclk_o)));

    // R9: a request during a busy cycle does not disturb the convert line
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (cnv_o && start_i && !last_bit) |=> cnv_o);

endmodule

// File: tb/tb_chain_adc_reader.sv
`timescale 1ns/1ps
module tb_chain_adc_reader;
    import chain_rd_pkg::*;

    localparam int unsigned N_DEV    = 3;
    localparam int unsigned HALF_DIV = 2;
    localparam int unsigned CONV_CYC = 12;
    localparam int unsigned TOT      = WORD_W * N_DEV;
    localparam int unsigned IW       = clog2_min1(N_DEV);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              cnv, sclk, sdi, valid;
    logic [WORD_W-1:0] word;
    logic [IW-1:0]     idx;

    logic [TOT-1:0]    load_val = '0;
    logic [TOT-1:0]    chain_q  = '0;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    chain_adc_reader #(.N_DEV(N_DEV), .HALF_DIV(HALF_DIV), .CONV_CYC(CONV_CYC)) dut (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start),
        .cnv_o        (cnv),
        .sclk_o       (sclk),
        .sdi_i        (sdi),
        .word_o       (word),
        .word_valid_o (valid),
        .word_idx_o   (idx)
    );

    // behavioural chain: nearest device word sits at the top of the register
    assign sdi = chain_q[TOT-1];
    always @(posedge cnv)  chain_q = load_val;
    always @(negedge sclk) chain_q = {chain_q[TOT-2:0], 1'b0};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [WORD_W-1:0] pattern(input int t, input int k);
        logic [WORD_W-1:0] m;
        m = '1;
        case (t)
            0: return '0;
            1: return m;
            2: return (k % 2 == 0) ? 18'h2AAAA : 18'h15555;
            3: return 18'(1) << ((k * 5 + 1) % WORD_W);
            4: return 18'((k * 32'h1357 + 32'h0F0F1) & 32'h3FFFF);
            5: return ~(18'(1) << (WORD_W - 1 - k));
            6: return 18'((k + 1) * 32'h0B6D3 & 32'h3FFFF);
            default: return 18'h20001 ^ 18'(k);
        endcase
    endfunction

    task automatic run_trial(input int t, input bit inject);
        int n, len, rises, vcount, cyc;
        bit prev, pv, idle_ok;
        for (int k = 0; k < N_DEV; k++)
            load_val[TOT-1-WORD_W*k -: WORD_W] = pattern(t, k);

        @(negedge clk) start = 1'b1;
        @(negedge clk) start = inject;
        chk(cnv == 1'b1, "R2 cnv", int'(cnv), 1);
        chk(sclk == 1'b0, "R2 sclk", int'(sclk), 0);

        n = 0;
        while (!sclk && n < 1000) begin
            @(negedge clk);
            start = 1'b0;
            n++;
        end
        chk(n == CONV_CYC + HALF_DIV, "R3 first rise delay", n, CONV_CYC + HALF_DIV);

        prev = 1'b1; len = 1; rises = 1; vcount = 0; cyc = 0; pv = 1'b0;
        while (cyc < 5000) begin
            @(negedge clk);
            cyc++;
            start = inject && (cyc >= 40 && cyc < 44);
            if (sclk != prev) begin
                chk(len == HALF_DIV, "R3 phase length", len, HALF_DIV);
                len = 1;
                if (sclk) rises++;
                prev = sclk;
            end else begin
                len++;
            end
            if (valid) begin
                chk(!pv, "R7 strobe width", int'(pv), 0);
                chk(int'(idx) == vcount, "R7 index order", int'(idx), vcount);
                chk(word == load_val[TOT-1-WORD_W*vcount -: WORD_W], "R6 word value",
                    int'(word), int'(load_val[TOT-1-WORD_W*vcount -: WORD_W]));
                vcount++;
            end
            pv = valid;
            if (!cnv) begin
                chk(rises == TOT, "R4 cnv held to last pulse", rises, TOT);
                chk(sclk == 1'b0, "R8 sclk low at end", int'(sclk), 0);
                break;
            end
        end
        start = 1'b0;
        chk(rises == TOT, "R5 pulse count", rises, TOT);
        chk(vcount == N_DEV, "R7 word count", vcount, N_DEV);

        idle_ok = 1'b1;
        repeat (8) begin
            @(negedge clk);
            if (cnv || sclk || valid) idle_ok = 1'b0;
        end
        chk(idle_ok, inject ? "R9 idle after ignored start" : "R8 idle after read",
            int'(idle_ok), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!cnv && !sclk && !valid, "R1 in reset", int'({cnv, sclk, valid}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!cnv && !sclk && !valid, "R1 after reset", int'({cnv, sclk, valid}), 0);
        for (int t = 0; t < 8; t++)
            run_trial(t, (t == 3) || (t == 6));
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule